// File: doc/BRIEF.md
# MDIO Management Slave with Register Bank

This block is the device side of a two-wire management bus. It oversamples the management clock and data lines with a fast system clock. It decodes serial frames sent by a bus master and serves reads and writes on a bank of thirty-two 16-bit registers. A small set of those registers holds fixed identity and status words. The bus is shared by many devices, so the block answers only frames that carry its own 5-bit device address. It samples that address from five strap pins while reset is held.

The master owns the management clock and may stop it whenever the bus is idle. All frame progress therefore comes from management clock edges, and no timer runs on the system clock. For a read, the block keeps its output enable low for the first turnaround bit. It drives a zero for the second turnaround bit, then shifts out the register word starting with the most significant bit. Every change on the output pins is made just after a falling management clock edge. The bus has an external pull-up, so an undriven line reads as one.

Top module: `mdio_slave_regs`

## Requirements
- R1: `mdc` and `mdio_in` pass through a synchronizer of at least two stages. Each frame bit is the value of `mdio_in` taken at a rising edge of `mdc`. Fields go most significant bit first, in this order: start (0 then 1), opcode (2 bits), device address (5 bits), register address (5 bits), turnaround (2 bits), data (16 bits).
- R2: While `rst_n` is low the block loads the device address from `strap_addr`. After release it keeps that address, whatever `strap_addr` does.
- R3: A frame whose device address differs from the loaded one writes nothing, and the block never raises `mdio_oe` during it.
- R4: The first rising edge of `mdc` after reset release is discarded. It does not count as a preamble bit.
- R5: A frame starts only after at least 32 consecutive one bits, followed by the start pattern. A frame with a shorter preamble is ignored.
- R6: Opcode 10 is a read and opcode 01 is a write. A frame with opcode 00 or 11 is discarded: no register changes and the line is not driven.
- R7: During a read, `mdio_oe` is low for the first turnaround bit. The block drives 0 for the second turnaround bit, then drives the 16 data bits MSB first. After reset `mdio_oe` is 0 and `mdio_out` is 1.
- R8: During a write the two turnaround bits are ignored. The 16 data bits are written into the addressed register after the sixteenth data bit, and the line is never driven.
- R9: Registers 1, 2 and 3 are read-only and hold 16'h782D, 16'h1A2B and 16'h3C4D. Writes to them are ignored. All other registers reset to 0.
- R10: `mdio_oe` is released on the falling `mdc` edge after the last read data bit. The block then waits for a new preamble, so frames can follow back to back.
- R11: `mdio_oe` and `mdio_out` change only in reaction to a falling `mdc` edge.
- R12: `mdc` may stop for any length of time between frames. The next frame is decoded normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low synchronous reset; straps are loaded while it is low |
| strap_addr | input | 5 | Strap pins that set the device address |
| mdc | input | 1 | Management clock from the bus master |
| mdio_in | input | 1 | Management data line as seen at the pad |
| mdio_out | output | 1 | Value driven onto the data line |
| mdio_oe | output | 1 | Output enable for the data line pad |

## Verification
The bench builds the block with a three-stage synchronizer. All other parameters keep their defaults: a 32-bit preamble, 5-bit addresses, 16-bit words and registers 1 to 3 read-only. The deeper synchronizer adds latency between a falling `mdc` edge and the pad change. The checks confirm that this latency still fits inside the low half of the bus clock. With the default preamble length, the first discarded edge after reset turns an exact 32-bit preamble into a rejected frame. Two reset cycles with different strap values cover both the address latch and the reset state of the registers.

// File: rtl/mdio_slv_pkg.sv
package mdio_slv_pkg;
   typedef enum logic [2:0] {
      FS_PRE,
      FS_SOF,
      FS_OP,
      FS_PHY,
      FS_REG,
      FS_RD,
      FS_WR
   } fstate_e;

   localparam logic [1:0] OPC_RD = 2'b10;
   localparam logic [1:0] OPC_WR = 2'b01;
endpackage

// File: rtl/mdio_edge_sync.sv
module mdio_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mdc_pin,
   input  logic mdio_pin,
   output logic mdc_rise,
   output logic mdc_fall,
   output logic mdio_bit
);
   logic [STAGES-1:0] mdc_sh;
   logic [STAGES-1:0] dat_sh;
   logic              mdc_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mdc_sh <= '0;
         dat_sh <= '1;
         mdc_d  <= 1'b0;
      end else begin
         mdc_sh <= {mdc_sh[STAGES-2:0], mdc_pin};
         dat_sh <= {dat_sh[STAGES-2:0], mdio_pin};
         mdc_d  <= mdc_sh[STAGES-1];
      end
   end

   // data travels through the same depth as the clock, so it is aligned
   assign mdc_rise = mdc_sh[STAGES-1] & ~mdc_d;
   assign mdc_fall = ~mdc_sh[STAGES-1] & mdc_d;
   assign mdio_bit = dat_sh[STAGES-1];
endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
   import mdio_slv_pkg::*;
#(
   parameter int PRE_LEN = 32,
   parameter int PW      = 5,
   parameter int AW      = 5,
   parameter int DW      = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mdc_rise,
   input  logic          mdc_fall,
   input  logic          bit_in,
   input  logic [PW-1:0] my_addr,
   input  logic [DW-1:0] rd_data,
   output logic [AW-1:0] rd_addr,
   output logic          wr_en,
   output logic [AW-1:0] wr_addr,
   output logic [DW-1:0] wr_data,
   output logic          mdio_o,
   output logic          mdio_oe
);
   localparam int PCW = $clog2(PRE_LEN + 1);
   localparam int CW  = $clog2(DW + 2);
   localparam logic [PCW-1:0] PRE_FULL = PCW'(PRE_LEN);
   localparam logic [CW-1:0]  LAST     = CW'(DW + 1);
   localparam logic [CW-1:0]  PA_END   = CW'(PW - 1);
   localparam logic [CW-1:0]  RA_END   = CW'(AW - 1);

   fstate_e        st;
   logic           armed;
   logic [PCW-1:0] pcnt;
   logic [CW-1:0]  cnt;
   logic [1:0]     op_q;
   logic [PW-1:0]  pa_q;
   logic [AW-1:0]  ra_q;
   logic [DW-1:0]  wsh;
   logic [DW-1:0]  rsh;
   logic           hit;

   assign rd_addr = {ra_q[AW-2:0], bit_in};
   assign hit     = (pa_q == my_addr);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= FS_PRE;
         armed   <= 1'b0;
         pcnt    <= '0;
         cnt     <= '0;
         op_q    <= '0;
         pa_q    <= '0;
         ra_q    <= '0;
         wsh     <= '0;
         rsh     <= '0;
         wr_en   <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
         mdio_o  <= 1'b1;
         mdio_oe <= 1'b0;
      end else begin
         wr_en <= 1'b0;
         if (mdc_rise) begin
            if (!armed) begin
               armed <= 1'b1;
            end else begin
               case (st)
                  FS_PRE: begin
                     if (bit_in) begin
                        if (pcnt != PRE_FULL) pcnt <= pcnt + 1'b1;
                     end else begin
                        if (pcnt == PRE_FULL) st <= FS_SOF;
                        pcnt <= '0;
                     end
                  end
                  FS_SOF: begin
                     st  <= bit_in ? FS_OP : FS_PRE;
                     cnt <= '0;
                  end
                  FS_OP: begin
                     op_q <= {op_q[0], bit_in};
                     if (cnt == CW'(1)) begin
                        st  <= FS_PHY;
                        cnt <= '0;
                     end else begin
                        cnt <= cnt + 1'b1;
                     end
                  end
                  FS_PHY: begin
                     pa_q <= {pa_q[PW-2:0], bit_in};
                     if (cnt == PA_END) begin
                        st  <= FS_REG;
                        cnt <= '0;
                     end else begin
                        cnt <= cnt + 1'b1;
                     end
                  end
                  FS_REG: begin
                     ra_q <= rd_addr;
                     if (cnt == RA_END) begin
                        cnt <= '0;
                        if (hit && op_q == OPC_RD) begin
                           st  <= FS_RD;
                           rsh <= rd_data;
                        end else if (hit && op_q == OPC_WR) begin
                           st <= FS_WR;
                        end else begin
                           st <= FS_PRE;
                        end
                     end else begin
                        cnt <= cnt + 1'b1;
                     end
                  end
                  FS_RD: begin
                     if (cnt == LAST) st <= FS_PRE;
                     else cnt <= cnt + 1'b1;
                  end
                  FS_WR: begin
                     if (cnt >= CW'(2)) wsh <= {wsh[DW-2:0], bit_in};
                     if (cnt == LAST) begin
                        wr_en   <= 1'b1;
                        wr_addr <= ra_q;
                        wr_data <= {wsh[DW-2:0], bit_in};
                        st      <= FS_PRE;
                     end else begin
                        cnt <= cnt + 1'b1;
                     end
                  end
                  default: st <= FS_PRE;
               endcase
            end
         end
         if (mdc_fall) begin
            if (st == FS_RD && cnt != '0) begin
               mdio_oe <= 1'b1;
               if (cnt == CW'(1)) begin
                  mdio_o <= 1'b0;
               end else begin
                  mdio_o <= rsh[DW-1];
                  rsh    <= {rsh[DW-2:0], 1'b0};
               end
            end else begin
               mdio_oe <= 1'b0;
               mdio_o  <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/mdio_reg_bank.sv
module mdio_reg_bank #(
   parameter int AW = 5,
   parameter int DW = 16,
   parameter logic [(1<<AW)-1:0] RO_MASK = 'hE,
   parameter logic [DW-1:0] STATUS_WORD = 16'h782D,
   parameter logic [DW-1:0] ID_HI       = 16'h1A2B,
   parameter logic [DW-1:0] ID_LO       = 16'h3C4D
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data
);
   localparam int NREG = 1 << AW;

   function automatic logic [DW-1:0] fixed_word(input int idx);
      case (idx)
         1:       return STATUS_WORD;
         2:       return ID_HI;
         3:       return ID_LO;
         default: return '0;
      endcase
   endfunction

   logic [DW-1:0] regs [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      if (RO_MASK[i]) begin : g_ro
         assign regs[i] = fixed_word(i);
      end else begin : g_rw
         always_ff @(posedge clk) begin
            if (!rst_n) regs[i] <= '0;
            else if (wr_en && wr_addr == AW'(i)) regs[i] <= wr_data;
         end
      end
   end

   assign rd_data = regs[rd_addr];
endmodule

// File: rtl/mdio_slave_regs.sv
module mdio_slave_regs #(
   parameter int SYNC_STAGES = 2,
   parameter int PRE_LEN     = 32,
   parameter int PHYAD_W     = 5,
   parameter int REG_AW      = 5,
   parameter int DATA_W      = 16,
   parameter logic [(1<<REG_AW)-1:0] RO_MASK = 'hE,
   parameter logic [DATA_W-1:0] STATUS_WORD = 16'h782D,
   parameter logic [DATA_W-1:0] ID_HI       = 16'h1A2B,
   parameter logic [DATA_W-1:0] ID_LO       = 16'h3C4D
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [PHYAD_W-1:0] strap_addr,
   input  logic               mdc,
   input  logic               mdio_in,
   output logic               mdio_out,
   output logic               mdio_oe
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (PRE_LEN < 1) begin : g_bad_pre
      $error("PRE_LEN must be positive");
   end
   if (REG_AW < 2 || PHYAD_W < 2) begin : g_bad_aw
      $error("address fields need at least 2 bits");
   end
   if (DATA_W < REG_AW || DATA_W < PHYAD_W || DATA_W < 2) begin : g_bad_dw
      $error("DATA_W too small for the field counters");
   end

   logic               mdc_rise_w;
   logic               mdc_fall_w;
   logic               bit_w;
   logic [PHYAD_W-1:0] phy_addr_q;
   logic [REG_AW-1:0]  bank_raddr;
   logic [DATA_W-1:0]  bank_rdata;
   logic               bank_we;
   logic [REG_AW-1:0]  bank_waddr;
   logic [DATA_W-1:0]  bank_wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) phy_addr_q <= strap_addr;
   end

   mdio_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .mdc_pin  (mdc),
      .mdio_pin (mdio_in),
      .mdc_rise (mdc_rise_w),
      .mdc_fall (mdc_fall_w),
      .mdio_bit (bit_w)
   );

   mdio_frame_fsm #(
      .PRE_LEN (PRE_LEN),
      .PW      (PHYAD_W),
      .AW      (REG_AW),
      .DW      (DATA_W)
   ) fsm_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .mdc_rise (mdc_rise_w),
      .mdc_fall (mdc_fall_w),
      .bit_in   (bit_w),
      .my_addr  (phy_addr_q),
      .rd_data  (bank_rdata),
      .rd_addr  (bank_raddr),
      .wr_en    (bank_we),
      .wr_addr  (bank_waddr),
      .wr_data  (bank_wdata),
      .mdio_o   (mdio_out),
      .mdio_oe  (mdio_oe)
   );

   mdio_reg_bank #(
      .AW          (REG_AW),
      .DW          (DATA_W),
      .RO_MASK     (RO_MASK),
      .STATUS_WORD (STATUS_WORD),
      .ID_HI       (ID_HI),
      .ID_LO       (ID_LO)
   ) bank_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bank_we),
      .wr_addr (bank_waddr),
      .wr_data (bank_wdata),
      .rd_addr (bank_raddr),
      .rd_data (bank_rdata)
   );
endmodule

// File: rtl/mdio_slave_regs_chk.sv
module mdio_slave_regs_chk #(
   parameter int PW = 5
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mdio_oe,
   input logic          mdio_out,
   input logic          mdc_rise,
   input logic          mdc_fall,
   input logic          bank_we,
   input logic [PW-1:0] phy_addr
);
   AST_DRIVE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(mdio_oe) || !$stable(mdio_out)) |-> $past(mdc_fall)); // R11

   AST_TA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mdio_oe) |-> !mdio_out); // R7

   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(phy_addr)); // R2

   AST_WE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      bank_we |-> $past(mdc_rise)); // R8

   AST_WR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      bank_we |-> !mdio_oe); // R8

   AST_RST_QUIET: assert property (@(posedge clk)
      !rst_n |=> !mdio_oe); // R10
endmodule

bind mdio_slave_regs mdio_slave_regs_chk #(.PW(PHYAD_W)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .mdio_oe  (mdio_oe),
   .mdio_out (mdio_out),
   .mdc_rise (mdc_rise_w),
   .mdc_fall (mdc_fall_w),
   .bank_we  (bank_we),
   .phy_addr (phy_addr_q)
);

// File: tb/mdio_slave_regs_tb_top.sv
`timescale 1ns/1ps
module mdio_slave_regs_tb_top;
   localparam int HALF = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mdc = 1'b0;
   logic [4:0] strap = 5'h0A;
   logic       m_en = 1'b0;
   logic       m_val = 1'b1;
   logic       mdio_oe;
   logic       mdio_out;
   logic       mdio_line;

   assign mdio_line = mdio_oe ? mdio_out : (m_en ? m_val : 1'b1);

   always #2.5 clk = ~clk;

   mdio_slave_regs #(.SYNC_STAGES(3)) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .strap_addr (strap),
      .mdc        (mdc),
      .mdio_in    (mdio_line),
      .mdio_out   (mdio_out),
      .mdio_oe    (mdio_oe)
   );

   typedef struct {
      logic [15:0] val;
      string       tag;
   } exp_t;

   int          total = 0;
   int          bad = 0;
   int          oe_glitch = 0;
   bit          done = 1'b0;
   logic [4:0]  my_pa;
   bit          first_rise;
   logic [15:0] model [32];
   exp_t        exp_q [$];
   logic [15:0] got;
   event        rd_ev;
   logic        seen_oe = 1'b0;
   logic        oe_d = 1'b0;
   logic        out_d = 1'b1;

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic bit is_ro(input int a);
      return (a == 1) || (a == 2) || (a == 3);
   endfunction

   task automatic model_reset();
      for (int i = 0; i < 32; i++) model[i] = 16'h0000;
      model[1] = 16'h782D;
      model[2] = 16'h1A2B;
      model[3] = 16'h3C4D;
   endtask

   task automatic do_reset(input logic [4:0] s);
      rst_n = 1'b0;
      strap = s;
      repeat (10) @(negedge clk);
      my_pa = s;
      model_reset();
      first_rise = 1'b1;
      rst_n = 1'b1;
      @(negedge clk);
      strap = ~s;
   endtask

   task automatic mbit(input logic drv, input logic v, output logic s);
      m_en = drv;
      m_val = v;
      repeat (HALF) @(negedge clk);
      s = mdio_line;
      mdc = 1'b1;
      repeat (HALF) @(negedge clk);
      mdc = 1'b0;
   endtask

   task automatic frame(input logic [1:0] op, input logic [4:0] pa, input logic [4:0] ra,
                        input logic [15:0] wd, input int npre, input string tag);
      logic        s;
      logic [15:0] cap;
      bit          act;
      int          eff;
      eff = first_rise ? npre - 1 : npre;
      first_rise = 1'b0;
      act = (pa == my_pa) && (eff >= 32) && (op == 2'b10 || op == 2'b01);
      cap = '0;
      for (int i = 0; i < npre; i++) mbit(1'b1, 1'b1, s);
      mbit(1'b1, 1'b0, s);
      mbit(1'b1, 1'b1, s);
      for (int i = 1; i >= 0; i--) mbit(1'b1, op[i], s);
      for (int i = 4; i >= 0; i--) mbit(1'b1, pa[i], s);
      for (int i = 4; i >= 0; i--) mbit(1'b1, ra[i], s);
      seen_oe = 1'b0;
      if (op == 2'b10) begin
         mbit(1'b0, 1'b1, s);
         check(!seen_oe && s == 1'b1, "R7", "first turnaround undriven", {31'd0, s}, 32'd1);
         mbit(1'b0, 1'b1, s);
         if (act) check(s == 1'b0, "R7", "second turnaround zero", {31'd0, s}, 32'd0);
         for (int i = 0; i < 16; i++) begin
            mbit(1'b0, 1'b1, s);
            cap = {cap[14:0], s};
         end
         if (act) begin
            exp_q.push_back('{model[ra], tag});
            got = cap;
            ->rd_ev;
         end else begin
            check(!seen_oe && cap == 16'hFFFF, tag, "no drive on ignored read",
                  {15'd0, seen_oe, cap}, 32'h0000FFFF);
         end
      end else begin
         mbit(1'b1, 1'b1, s);
         mbit(1'b1, 1'b0, s);
         for (int i = 15; i >= 0; i--) mbit(1'b1, wd[i], s);
         if (act && !is_ro(ra)) model[ra] = wd;
         check(!seen_oe, tag, "no drive during write or discarded frame", {31'd0, seen_oe}, 32'd0);
      end
      m_en = 1'b0;
      repeat (6) @(negedge clk);
      check(!mdio_oe, "R10", "output enable released after frame", {31'd0, mdio_oe}, 32'd0);
   endtask

   // scoreboard monitor
   initial begin
      exp_t e;
      forever begin
         @(rd_ev);
         e = exp_q.pop_front();
         check(got == e.val, e.tag, "read data", {16'd0, got}, {16'd0, e.val});
      end
   end

   // pad activity tracker, R11 observation
   always @(negedge clk) begin
      if (mdio_oe) seen_oe = 1'b1;
      if (rst_n && mdc && (mdio_oe !== oe_d || mdio_out !== out_d)) oe_glitch++;
      oe_d = mdio_oe;
      out_d = mdio_out;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      do_reset(5'h0A);
      check(mdio_oe == 1'b0 && mdio_out == 1'b1, "R7", "idle state after reset",
            {30'd0, mdio_oe, mdio_out}, 32'd1);

      // R4: exact 32-bit preamble right after reset loses its first bit
      frame(2'b01, 5'h0A, 5'd5, 16'hBEEF, 32, "R4");
      frame(2'b10, 5'h0A, 5'd5, 16'h0000, 32, "R4");

      // R8 / R1: writes and read-backs with several patterns
      frame(2'b01, 5'h0A, 5'd5, 16'hBEEF, 32, "R8");
      frame(2'b10, 5'h0A, 5'd5, 16'h0000, 32, "R8");
      frame(2'b01, 5'h0A, 5'd0, 16'hA5A5, 32, "R1");
      frame(2'b01, 5'h0A, 5'd31, 16'h5A5A, 32, "R1");
      frame(2'b10, 5'h0A, 5'd0, 16'h0000, 32, "R1");
      frame(2'b10, 5'h0A, 5'd31, 16'h0000, 32, "R1");

      // R9: read-only words
      frame(2'b01, 5'h0A, 5'd2, 16'hFFFF, 32, "R9");
      frame(2'b10, 5'h0A, 5'd2, 16'h0000, 32, "R9");
      frame(2'b10, 5'h0A, 5'd1, 16'h0000, 32, "R9");
      frame(2'b10, 5'h0A, 5'd3, 16'h0000, 32, "R9");

      // R2 / R3: strap pins now read 0x15; only 0x0A answers
      frame(2'b01, 5'h15, 5'd6, 16'h1234, 32, "R3");
      frame(2'b10, 5'h15, 5'd6, 16'h0000, 32, "R3");
      frame(2'b10, 5'h0A, 5'd6, 16'h0000, 32, "R2");

      // R6: invalid opcodes
      frame(2'b11, 5'h0A, 5'd7, 16'h7777, 32, "R6");
      frame(2'b00, 5'h0A, 5'd7, 16'h7777, 32, "R6");
      frame(2'b10, 5'h0A, 5'd7, 16'h0000, 32, "R6");

      // R5: preamble length
      frame(2'b01, 5'h0A, 5'd8, 16'hC3C3, 31, "R5");
      frame(2'b10, 5'h0A, 5'd8, 16'h0000, 40, "R5");
      frame(2'b01, 5'h0A, 5'd8, 16'hC3C3, 33, "R5");
      frame(2'b10, 5'h0A, 5'd8, 16'h0000, 32, "R5");

      // R12: long idle with MDC stopped
      repeat (3000) @(negedge clk);
      frame(2'b01, 5'h0A, 5'd9, 16'h0F0F, 32, "R12");
      repeat (2500) @(negedge clk);
      frame(2'b10, 5'h0A, 5'd9, 16'h0000, 32, "R12");

      // R2: second reset with a different strap value
      do_reset(5'h1F);
      frame(2'b10, 5'h1F, 5'd5, 16'h0000, 33, "R2");
      frame(2'b10, 5'h0A, 5'd5, 16'h0000, 32, "R2");
      frame(2'b01, 5'h1F, 5'd12, 16'h8001, 32, "R2");
      frame(2'b10, 5'h1F, 5'd12, 16'h0000, 32, "R2");

      repeat (20) @(negedge clk);
      check(oe_glitch == 0, "R11", "pad changes while MDC high", oe_glitch, 32'd0);
      check(exp_q.size() == 0, "R7", "reads left unanswered", exp_q.size(), 32'd0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule